// File: doc/BRIEF.md
# Legacy Real-Mode Memory Window Decoder

This block steers every memory access of a real-mode processor core to the right backing store. A request carries a 20-bit byte address, a read/write direction and an access size of one, two or four bytes. The block chooses one of four destinations: an option-ROM image buffer, a video-memory window, a small built-in identification ROM, or main RAM. It then turns the address into an offset inside that destination.

The destination stores sit outside the block. They see one shared offset, size and write-data bus, plus an enable for each store. Each store returns a 32-bit little-endian word read from that offset. The block picks the returned word of the selected store, clears the bytes the access size does not cover, and registers it as the response. When video emulation is enabled, the video range is blanked: reads there return zero and writes there reach nothing.

Accesses that land in the suspect region just above the option ROM, or beyond the configured RAM size, are redirected to RAM offset 0. Each of these raises a sticky flag that stays set until reset.

Top module: `rmw_window_decoder`

## Requirements
- R1: At most one of `rom_en`, `vid_en`, `ram_en` is high in any cycle, and all three stay low while `req_valid` is low. Decoding follows a fixed priority: blanking, option ROM, suspect gap, video, identification ROM, RAM size check, plain RAM.
- R2: An address from 0xC0000 up to `orom_limit` inclusive enables `rom_en` with `mem_off` equal to the address minus 0xC0000. A change of `orom_limit` takes effect on the next access.
- R3: An address above `orom_limit` and below 0xD0000 enables `ram_en` with `mem_off` 0 and sets `warn_flag`. Once set, `warn_flag` stays high until reset.
- R4: With `vid_emul_en` low, an address from 0xA0000 to 0xBFFFF enables `vid_en` with `mem_off` equal to the address minus 0xA0000.
- R5: With `vid_emul_en` high, an access starting from 0xA0000 to 0xBFFFF raises no store enable, whatever its size. A read there returns 0, and a write there leaves the video store unchanged.
- R6: Addresses 0xFFFF5 to 0xFFFFF read from the internal identification ROM, which raises no store enable. The bytes are the date text "05/17/98" as ASCII (0x30 0x35 0x2F 0x31 0x37 0x2F 0x39 0x38), then 0x00, then the model byte 0xFC at 0xFFFFE and the submodel byte 0x00 at 0xFFFFF. Lanes past 0xFFFFF read 0. Writes to this ROM change nothing.
- R7: Any other address that is at or above `ram_size` enables `ram_en` with `mem_off` 0 and sets `halt_flag`. Once set, `halt_flag` stays high until reset.
- R8: All remaining addresses enable `ram_en` with `mem_off` equal to the address.
- R9: `req_size` is encoded as 0 for a byte, 1 for a word, and 2 or 3 for a dword. Only the start address is decoded. Bytes are little-endian, lowest address in bits 7:0, and lanes beyond the size read as zero in `rsp_rdata`.
- R10: A read accepted at a clock edge gives `rsp_valid` high with its data after that edge, for one cycle. A write gives no response. The flags update at the same edge as the access.
- R11: Reset clears `rsp_valid`, `warn_flag` and `halt_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| req_addr | input | 20 | Byte start address |
| req_wdata | input | 32 | Write data, little-endian |
| vid_emul_en | input | 1 | Blank the video range |
| orom_limit | input | 20 | Last option-ROM address, inclusive |
| ram_size | input | 21 | Main RAM size in bytes |
| mem_off | output | 20 | Offset into the selected store |
| mem_size | output | 2 | Access size passed to the store |
| mem_wdata | output | 32 | Write data passed to the store |
| mem_we | output | 1 | Write strobe, qualified by an enable |
| rom_en | output | 1 | Option-ROM buffer selected |
| vid_en | output | 1 | Video window selected |
| ram_en | output | 1 | Main RAM selected |
| rom_rdata | input | 32 | Option-ROM word at `mem_off` |
| vid_rdata | input | 32 | Video word at `mem_off` |
| ram_rdata | input | 32 | RAM word at `mem_off` |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| warn_flag | output | 1 | Sticky suspect-gap flag |
| halt_flag | output | 1 | Sticky out-of-RAM flag |

## Verification
Accesses are aimed at both edges of every region: 0xC7FFF against 0xC8000 for a given ROM limit, 0xBFFFF, 0xFFFF4 against 0xFFFF5, and the last in-range RAM byte against the first out-of-range one. These show whether the comparisons are inclusive or exclusive. The same video address is accessed with emulation on and then off, which separates blanking from routing. A write made while blanking is read back afterwards, to show the write really went nowhere. Identification reads use all three sizes and start on the last bytes, which tells the lane ordering apart from the zero fill past the top of memory. Moving the ROM limit at run time shows that the gap boundary follows the input.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int RSZ_W   = ADDR_W + 1;
    localparam int IDIX_W  = 5;

    localparam logic [ADDR_W-1:0] VID_LO    = 20'hA0000;
    localparam logic [ADDR_W-1:0] VID_HI    = 20'hBFFFF;
    localparam logic [ADDR_W-1:0] OROM_BASE = 20'hC0000;
    localparam logic [ADDR_W-1:0] GAP_END   = 20'hD0000;
    localparam logic [ADDR_W-1:0] ID_BASE   = 20'hFFFF5;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_RAM, TGT_OROM, TGT_VID, TGT_IDROM
    } tgt_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_DWORD_ALT = 2'd3
    } size_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] off;
        logic              warn;
        logic              halt;
    } route_t;

    // identification ROM: date text, terminator, model, submodel
    function automatic logic [7:0] id_byte(input logic [IDIX_W-1:0] idx);
        case (idx)
            5'd0:    return 8'h30;
            5'd1:    return 8'h35;
            5'd2:    return 8'h2F;
            5'd3:    return 8'h31;
            5'd4:    return 8'h37;
            5'd5:    return 8'h2F;
            5'd6:    return 8'h39;
            5'd7:    return 8'h38;
            5'd9:    return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input size_e sz);
        case (sz)
            SZ_BYTE: return DATA_W'(32'h0000_00FF);
            SZ_WORD: return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/rmw_region_decode.sv
module rmw_region_decode
    import rmw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              emul,
    input  logic [ADDR_W-1:0] limit,
    input  logic [RSZ_W-1:0]  ram_size,
    output route_t            route
);
    logic in_vid;
    assign in_vid = (addr >= VID_LO) && (addr <= VID_HI);

    always_comb begin
        route.tgt  = TGT_RAM;
        route.off  = addr;
        route.warn = 1'b0;
        route.halt = 1'b0;
        if (emul && in_vid) begin
            route.tgt = TGT_NONE;
            route.off = '0;
        end else if (addr >= OROM_BASE && addr <= limit) begin
            route.tgt = TGT_OROM;
            route.off = addr - OROM_BASE;
        end else if (addr > limit && addr < GAP_END) begin
            route.off  = '0;
            route.warn = 1'b1;
        end else if (in_vid) begin
            route.tgt = TGT_VID;
            route.off = addr - VID_LO;
        end else if (addr >= ID_BASE) begin
            route.tgt = TGT_IDROM;
            route.off = addr - ID_BASE;
        end else if ({1'b0, addr} >= ram_size) begin
            route.off  = '0;
            route.halt = 1'b1;
        end
    end
endmodule

// File: rtl/rmw_id_rom.sv
module rmw_id_rom
    import rmw_pkg::*;
(
    input  logic [ADDR_W-1:0] off,
    output logic [DATA_W-1:0] word
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [IDIX_W-1:0] idx;
            assign idx = {1'b0, off[IDIX_W-2:0]} + IDIX_W'(g);
            assign word[g*8 +: 8] = id_byte(idx);
        end
    endgenerate
endmodule

// File: rtl/rmw_resp.sv
module rmw_resp
    import rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_read,
    input  size_e             size,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              set_warn,
    input  logic              set_halt,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              warn_flag,
    output logic              halt_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            warn_flag <= 1'b0;
            halt_flag <= 1'b0;
        end else begin
            rsp_valid <= acc_valid && acc_read;
            if (acc_valid && acc_read)
                rsp_rdata <= raw_data & size_mask(size);
            if (set_warn) warn_flag <= 1'b1;
            if (set_halt) halt_flag <= 1'b1;
        end
    end

    a_r10_read_responds: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_read) |=> rsp_valid);
    a_r10_write_silent: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_read) |=> !rsp_valid);
    a_r3_warn_sticky: assert property (@(posedge clk) disable iff (rst)
        warn_flag |=> warn_flag);
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt_flag |=> halt_flag);
    a_r9_byte_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_read && size == SZ_BYTE) |=> (rsp_rdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/rmw_window_decoder.sv
module rmw_window_decoder
    import rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              vid_emul_en,
    input  logic [ADDR_W-1:0] orom_limit,
    input  logic [RSZ_W-1:0]  ram_size,
    output logic [ADDR_W-1:0] mem_off,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              rom_en,
    output logic              vid_en,
    output logic              ram_en,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vid_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              warn_flag,
    output logic              halt_flag
);
    route_t            route;
    logic [DATA_W-1:0] id_word;
    logic [DATA_W-1:0] raw_data;

    rmw_region_decode u_decode (
        .addr     (req_addr),
        .emul     (vid_emul_en),
        .limit    (orom_limit),
        .ram_size (ram_size),
        .route    (route)
    );

    rmw_id_rom u_idrom (
        .off  (route.off),
        .word (id_word)
    );

    assign rom_en    = req_valid && (route.tgt == TGT_OROM);
    assign vid_en    = req_valid && (route.tgt == TGT_VID);
    assign ram_en    = req_valid && (route.tgt == TGT_RAM);
    assign mem_off   = route.off;
    assign mem_size  = req_size;
    assign mem_wdata = req_wdata;
    assign mem_we    = req_write;

    always_comb begin
        case (route.tgt)
            TGT_OROM:  raw_data = rom_rdata;
            TGT_VID:   raw_data = vid_rdata;
            TGT_RAM:   raw_data = ram_rdata;
            TGT_IDROM: raw_data = id_word;
            default:   raw_data = '0;
        endcase
    end

    rmw_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (req_valid),
        .acc_read  (!req_write),
        .size      (size_e'(req_size)),
        .raw_data  (raw_data),
        .set_warn  (req_valid && route.warn),
        .set_halt  (req_valid && route.halt),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .warn_flag (warn_flag),
        .halt_flag (halt_flag)
    );

    a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_en, vid_en, ram_en}));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(rom_en || vid_en || ram_en));
    a_r5_blank_no_enable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && vid_emul_en && req_addr >= VID_LO && req_addr <= VID_HI)
            |-> !(rom_en || vid_en || ram_en));
    a_r5_blank_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && vid_emul_en && req_addr >= VID_LO && req_addr <= VID_HI)
            |=> (rsp_rdata == '0));
    a_r6_idrom_no_enable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr >= ID_BASE) |-> !(rom_en || vid_en || ram_en));
endmodule

// File: tb/rmw_window_decoder_bench.sv
`timescale 1ns/1ps
module rmw_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, vid_emul_en;
    logic [1:0]  req_size;
    logic [19:0] req_addr, orom_limit, mem_off;
    logic [31:0] req_wdata, mem_wdata, rom_rdata, vid_rdata, ram_rdata, rsp_rdata;
    logic [20:0] ram_size;
    logic [1:0]  mem_size;
    logic        mem_we, rom_en, vid_en, ram_en, rsp_valid, warn_flag, halt_flag;

    int total = 0;
    int bad   = 0;
    bit exp_warn = 0;
    bit exp_halt = 0;

    logic [7:0] mrom [256];
    logic [7:0] mvid [256];
    logic [7:0] mram [256];
    logic [7:0] idstr [11] = '{8'h30, 8'h35, 8'h2F, 8'h31, 8'h37, 8'h2F,
                               8'h39, 8'h38, 8'h00, 8'hFC, 8'h00};

    always #2.5 clk = ~clk;

    rmw_window_decoder u_rmw_window_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .vid_emul_en(vid_emul_en), .orom_limit(orom_limit), .ram_size(ram_size),
        .mem_off(mem_off), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .rom_en(rom_en), .vid_en(vid_en), .ram_en(ram_en),
        .rom_rdata(rom_rdata), .vid_rdata(vid_rdata), .ram_rdata(ram_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .warn_flag(warn_flag), .halt_flag(halt_flag)
    );

    // backing stores: 256-byte arrays indexed by the low offset bits
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            rom_rdata[k*8 +: 8] = mrom[mem_off[7:0] + 8'(k)];
            vid_rdata[k*8 +: 8] = mvid[mem_off[7:0] + 8'(k)];
            ram_rdata[k*8 +: 8] = mram[mem_off[7:0] + 8'(k)];
        end
    end

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin
            for (int k = 0; k < nbytes(mem_size); k++) begin
                if (rom_en) mrom[mem_off[7:0] + 8'(k)] <= mem_wdata[k*8 +: 8];
                if (vid_en) mvid[mem_off[7:0] + 8'(k)] <= mem_wdata[k*8 +: 8];
                if (ram_en) mram[mem_off[7:0] + 8'(k)] <= mem_wdata[k*8 +: 8];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference routing: 0 none, 1 ram, 2 option rom, 3 video, 4 id rom
    task automatic model(input int a, output int tgt, output int off, output bit w, output bit h);
        bit invid = (a >= 'hA0000) && (a <= 'hBFFFF);
        w = 0; h = 0;
        if (vid_emul_en && invid) begin tgt = 0; off = 0; end
        else if (a >= 'hC0000 && a <= int'(orom_limit)) begin tgt = 2; off = a - 'hC0000; end
        else if (a > int'(orom_limit) && a < 'hD0000) begin tgt = 1; off = 0; w = 1; end
        else if (invid) begin tgt = 3; off = a - 'hA0000; end
        else if (a >= 'hFFFF5) begin tgt = 4; off = a - 'hFFFF5; end
        else if (a >= int'(ram_size)) begin tgt = 1; off = 0; h = 1; end
        else begin tgt = 1; off = a; end
    endtask

    function automatic logic [31:0] expect_read(input int tgt, input int off, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(sz); k++) begin
            logic [7:0] b;
            case (tgt)
                1: b = mram[8'(off + k)];
                2: b = mrom[8'(off + k)];
                3: b = mvid[8'(off + k)];
                4: b = (off + k < 11) ? idstr[off + k] : 8'h00;
                default: b = 8'h00;
            endcase
            v[k*8 +: 8] = b;
        end
        return v;
    endfunction

    task automatic access(input string req, input bit wr, input logic [1:0] sz,
                          input logic [19:0] a, input logic [31:0] wd,
                          output logic [31:0] got);
        int tgt, off; bit w, h;
        logic [31:0] exp_d;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        #1;
        model(int'(a), tgt, off, w, h);
        exp_d = expect_read(tgt, off, sz);
        check({req, " enables R1"}, {29'd0, rom_en, vid_en, ram_en},
              {29'd0, tgt == 2, tgt == 3, tgt == 1});
        if (tgt >= 1 && tgt <= 3) check({req, " offset"}, {12'd0, mem_off}, 32'(off));
        @(negedge clk);
        req_valid = 0;
        exp_warn |= w; exp_halt |= h;
        check({req, " flags R3 R7"}, {30'd0, warn_flag, halt_flag}, {30'd0, exp_warn, exp_halt});
        check({req, " rsp_valid R10"}, {31'd0, rsp_valid}, {31'd0, !wr});
        if (!wr) check({req, " data"}, rsp_rdata, exp_d);
        got = rsp_rdata;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, keep;
        for (int i = 0; i < 256; i++) begin
            mrom[i] = 8'(i ^ 8'h5A);
            mvid[i] = 8'(i * 3);
            mram[i] = 8'(~i);
        end
        rst = 1; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
        vid_emul_en = 0; orom_limit = 20'hC7FFF; ram_size = 21'h80000;
        repeat (3) @(negedge clk);
        check("reset R11", {29'd0, rsp_valid, warn_flag, halt_flag}, 32'd0);
        rst = 0;

        access("plain ram write R8", 1, 2'd2, 20'h00123, 32'hCAFE_F00D, r);
        access("plain ram read R8 R9", 0, 2'd2, 20'h00123, 0, r);
        check("ram readback R8", r, 32'hCAFE_F00D);
        access("ram word R9", 0, 2'd1, 20'h00124, 0, r);
        access("ram size3 dword R9", 0, 2'd3, 20'h00010, 0, r);
        access("last ram byte R7", 0, 2'd0, 20'h7FFFF, 0, r);
        access("orom write R2", 1, 2'd2, 20'hC0010, 32'h1122_3344, r);
        access("orom read R2", 0, 2'd2, 20'hC0010, 0, r);
        check("orom readback R2", r, 32'h1122_3344);
        access("orom limit byte R2", 0, 2'd0, 20'hC7FFF, 0, r);
        access("video write R4", 1, 2'd1, 20'hA0004, 32'h0000_BEEF, r);
        access("video read R4", 0, 2'd1, 20'hA0004, 0, r);
        check("video readback R4", r, 32'h0000_BEEF);
        access("video top byte R4", 0, 2'd0, 20'hBFFFF, 0, r);
        access("id dword low R6", 0, 2'd2, 20'hFFFF5, 0, r);
        check("id date text R6", r, 32'h312F_3530);
        access("id model byte R6", 0, 2'd0, 20'hFFFFE, 0, r);
        check("id model R6", r, 32'h0000_00FC);
        access("id word top R6", 0, 2'd1, 20'hFFFFE, 0, r);
        access("id dword straddle R6", 0, 2'd2, 20'hFFFFC, 0, r);
        check("id straddle R6", r, 32'h00FC_0038);
        access("id write ignored R6", 1, 2'd2, 20'hFFFF5, 32'hFFFF_FFFF, r);
        access("id after write R6", 0, 2'd2, 20'hFFFF5, 0, r);
        check("id unchanged R6", r, 32'h312F_3530);
        access("below id R7", 0, 2'd0, 20'hFFFF4, 0, r);
        vid_emul_en = 1;
        access("blank read R5", 0, 2'd2, 20'hA0004, 0, r);
        check("blank zero R5", r, 32'h0);
        access("blank byte read R5", 0, 2'd0, 20'hBFFFF, 0, r);
        access("blank write R5", 1, 2'd2, 20'hA0004, 32'hDEAD_DEAD, r);
        vid_emul_en = 0;
        access("after blank R5", 0, 2'd1, 20'hA0004, 0, r);
        check("blank write dropped R5", r, 32'h0000_BEEF);
        access("gap read R3", 0, 2'd0, 20'hC8000, 0, r);
        access("gap write R3", 1, 2'd0, 20'hCFFFF, 32'h0000_0077, r);
        access("gap readback R3", 0, 2'd0, 20'h00000, 0, r);
        check("gap lands at 0 R3", r, 32'h0000_0077);
        orom_limit = 20'hCFFFF;
        access("raised limit R2", 0, 2'd1, 20'hC8000, 0, r);
        access("halt read R7", 0, 2'd0, 20'h80000, 0, r);
        access("idle cycle R1", 0, 2'd0, 20'h00001, 0, keep);
        @(negedge clk);
        check("idle enables R1", {29'd0, rom_en, vid_en, ram_en}, 32'd0);
        check("idle no rsp R10", {31'd0, rsp_valid}, 32'd0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("reset clears flags R11", {30'd0, warn_flag, halt_flag}, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule